// File: doc/BRIEF.md
# Write-Protect Command Sequence Guard

This block sits between the write path of a nonvolatile memory and its array controller. For every write transaction (address, data, valid strobe) it decides in the same cycle whether the array may commit the byte, and raises `wr_permit` only for those that may. Writes are free while protection is off. Once protection is on, only writes inside a page-load window are let through. That window is opened by a fixed three-write unlock command.

The unlock command also switches protection on if it was off. After that, protection stays on by itself: each window admits one page load, and when the load ends the guard locks again. A longer six-write command arms a disable. Protection is then cleared when the program cycle that follows completes. The array side reports the end of a page load, the expiry of the byte-load time limit, or the end of a program cycle as a single pulse on `load_closed`.

The protection flag models a nonvolatile bit. A soft reset (`rst`) clears the sequence tracker, the window and any pending disable, but it leaves the flag as it was. Only `factory_clr` returns the flag to its as-delivered value, which is off.

Top module: `wp_guard`

## Requirements
- R1: After `factory_clr` is held for a clock edge, `prot_on` is 0, `win_open` is 0 and the sequence tracker is idle.
- R2: While `prot_on` is 0, a valid write that is not a command step has `wr_permit` high in the same cycle.
- R3: The three valid writes data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555, given in that order with no other valid write between them, set `prot_on` and `win_open` to 1 on the edge that takes the third write.
- R4: While the window is open, the first PAGE_BYTES (default 128) valid writes are permitted. Every later write is refused until the window closes.
- R5: A `load_closed` pulse clears `win_open` on that edge. `prot_on` stays 1.
- R6: While `prot_on` is 1 and the window is closed, every valid write has `wr_permit` low.
- R7: A valid write that does not match the expected next step sends the tracker back to idle, and the rest of the sequence no longer completes a command. That write is refused if protection is on and permitted if it is off.
- R8: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 arm a disable. `prot_on` stays 1 until the next `load_closed` pulse and falls to 0 on that edge. After that, writes are permitted.
- R9: A write that advances the tracker is a command step and never has `wr_permit` high, whatever the protection state.
- R10: Only address bits 14:0 are compared against the command addresses. Bit 15 is ignored.
- R11: `rst` closes the window and idles the tracker, but it does not change `prot_on`.
- R12: A `load_closed` pulse in the middle of a command sequence aborts it. The next command write is then out of order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high soft reset (flag kept) |
| factory_clr | input | 1 | Synchronous return to as-delivered state, protection off |
| wr_valid | input | 1 | Write transaction strobe |
| wr_addr | input | ADDR_W (16) | Write address |
| wr_data | input | 8 | Write data |
| load_closed | input | 1 | Pulse: page load finished, byte-load limit expired or program cycle done |
| wr_permit | output | 1 | Combinational: the current write may be stored in the array |
| prot_on | output | 1 | Protection flag (nonvolatile model) |
| win_open | output | 1 | Page-load window open |

## Verification
The bench looks for several ways the guard can get the sequence wrong. An unlock whose middle step was interrupted by a stray write must not open a window; a design that only looks at the most recent write would open one. An unlock interrupted by `load_closed` must also fail. It sends the window one byte over the page limit; a counter that is off by one lets that byte through. It runs the disable command and checks that protection holds until the closing pulse, so a design that clears the flag at once is caught. It pulses soft reset while protected, which catches a design that wipes the flag, and it uses command addresses with bit 15 set, which catches a full-width compare.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    localparam int CMP_W  = 15;
    localparam int BYTE_W = 8;

    localparam logic [CMP_W-1:0] ADDR_PRI = 15'h5555;
    localparam logic [CMP_W-1:0] ADDR_SEC = 15'h2AAA;

    localparam logic [BYTE_W-1:0] KEY_LEAD   = 8'hAA;
    localparam logic [BYTE_W-1:0] KEY_FOLLOW = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_OPEN   = 8'hA0;
    localparam logic [BYTE_W-1:0] KEY_ERASE  = 8'h80;
    localparam logic [BYTE_W-1:0] KEY_OFF    = 8'h20;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_K1,
        SEQ_K2,
        SEQ_K3,
        SEQ_K4,
        SEQ_K5
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        logic [CMP_W-1:0]  addr;
        logic [BYTE_W-1:0] data;
    } bus_wr_t;

    function automatic logic wr_is(bus_wr_t w, logic [CMP_W-1:0] a, logic [BYTE_W-1:0] d);
        return w.valid && (w.addr == a) && (w.data == d);
    endfunction

endpackage

// File: rtl/wp_seq_tracker.sv
module wp_seq_tracker
    import wp_guard_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_wr_t wr,
    input  logic    enable,
    input  logic    abort,
    output logic    cmd_step,
    output logic    unlock_hit,
    output logic    disable_hit
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d     = state_q;
        cmd_step    = 1'b0;
        unlock_hit  = 1'b0;
        disable_hit = 1'b0;
        if (abort) begin
            state_d = SEQ_IDLE;
        end else if (enable && wr.valid) begin
            state_d = SEQ_IDLE;
            case (state_q)
                SEQ_IDLE: if (wr_is(wr, ADDR_PRI, KEY_LEAD)) begin
                    cmd_step = 1'b1;
                    state_d  = SEQ_K1;
                end
                SEQ_K1: if (wr_is(wr, ADDR_SEC, KEY_FOLLOW)) begin
                    cmd_step = 1'b1;
                    state_d  = SEQ_K2;
                end
                SEQ_K2: if (wr_is(wr, ADDR_PRI, KEY_OPEN)) begin
                    cmd_step   = 1'b1;
                    unlock_hit = 1'b1;
                end else if (wr_is(wr, ADDR_PRI, KEY_ERASE)) begin
                    cmd_step = 1'b1;
                    state_d  = SEQ_K3;
                end
                SEQ_K3: if (wr_is(wr, ADDR_PRI, KEY_LEAD)) begin
                    cmd_step = 1'b1;
                    state_d  = SEQ_K4;
                end
                SEQ_K4: if (wr_is(wr, ADDR_SEC, KEY_FOLLOW)) begin
                    cmd_step = 1'b1;
                    state_d  = SEQ_K5;
                end
                SEQ_K5: if (wr_is(wr, ADDR_PRI, KEY_OFF)) begin
                    cmd_step    = 1'b1;
                    disable_hit = 1'b1;
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    // R12: an abort pulse mid-sequence leaves the tracker idle
    a_r12_abort_idles: assert property (@(posedge clk) disable iff (rst)
        (abort && state_q != SEQ_IDLE) |=> state_q == SEQ_IDLE);

    // R7: a valid write that is not a command step ends any open sequence
    a_r7_mismatch_idles: assert property (@(posedge clk) disable iff (rst)
        (enable && wr.valid && !cmd_step) |=> state_q == SEQ_IDLE);

    // R3: completing the unlock leaves a deeper step only from the second key
    a_r3_unlock_from_k2: assert property (@(posedge clk) disable iff (rst)
        unlock_hit |-> state_q == SEQ_K2);

endmodule

// File: rtl/wp_page_window.sv
module wp_page_window #(
    parameter int PAGE_BYTES = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic open_req,
    input  logic close_req,
    input  logic data_wr,
    output logic win_open,
    output logic room
);

    localparam int CNT_W = $clog2(PAGE_BYTES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PAGE_BYTES);

    logic [CNT_W-1:0] fill_q;

    assign room = (fill_q < LIMIT);

    always_ff @(posedge clk) begin
        if (rst || close_req) begin
            win_open <= 1'b0;
            fill_q   <= '0;
        end else if (open_req) begin
            win_open <= 1'b1;
            fill_q   <= '0;
        end else if (win_open && data_wr && room) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // R4: the byte count never passes the page size
    a_r4_fill_bounded: assert property (@(posedge clk) disable iff (rst)
        fill_q <= LIMIT);

    // R5: a close request always leaves the window shut
    a_r5_close_shuts: assert property (@(posedge clk) disable iff (rst)
        close_req |=> !win_open);

endmodule

// File: rtl/wp_prot_flag.sv
module wp_prot_flag (
    input  logic clk,
    input  logic rst,
    input  logic factory_clr,
    input  logic set_req,
    input  logic disarm_req,
    input  logic commit,
    output logic prot_on
);

    logic pend_q;

    // nonvolatile model: only the factory clear touches it, never rst (R11)
    always_ff @(posedge clk) begin
        if (factory_clr)             prot_on <= 1'b0;
        else if (set_req)            prot_on <= 1'b1;
        else if (commit && pend_q)   prot_on <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || factory_clr)  pend_q <= 1'b0;
        else if (set_req)        pend_q <= 1'b0;
        else if (disarm_req)     pend_q <= 1'b1;
        else if (commit)         pend_q <= 1'b0;
    end

    // R3: protection only rises from an unlock command
    a_r3_rise_from_unlock: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_on) |-> $past(set_req));

    // R8: protection only falls on a commit after an armed disable, or a factory clear
    a_r8_fall_from_commit: assert property (@(posedge clk) disable iff (rst)
        $fell(prot_on) |-> ($past(factory_clr) || ($past(commit) && $past(pend_q))));

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              factory_clr,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              load_closed,
    output logic              wr_permit,
    output logic              prot_on,
    output logic              win_open
);

    bus_wr_t wr_bus;
    logic    cmd_step, unlock_hit, disable_hit, room;
    logic    seq_rst;

    assign seq_rst = rst || factory_clr;
    assign wr_bus  = '{valid: wr_valid, addr: wr_addr[CMP_W-1:0], data: wr_data};

    generate
        if (ADDR_W > CMP_W) begin : g_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^wr_addr[ADDR_W-1:CMP_W];
        end
    endgenerate

    wp_seq_tracker u_seq (
        .clk         (clk),
        .rst         (seq_rst),
        .wr          (wr_bus),
        .enable      (!win_open),
        .abort       (load_closed),
        .cmd_step    (cmd_step),
        .unlock_hit  (unlock_hit),
        .disable_hit (disable_hit)
    );

    wp_page_window #(.PAGE_BYTES(PAGE_BYTES)) u_win (
        .clk       (clk),
        .rst       (seq_rst),
        .open_req  (unlock_hit),
        .close_req (load_closed),
        .data_wr   (wr_valid),
        .win_open  (win_open),
        .room      (room)
    );

    wp_prot_flag u_prot (
        .clk         (clk),
        .rst         (rst),
        .factory_clr (factory_clr),
        .set_req     (unlock_hit),
        .disarm_req  (disable_hit),
        .commit      (load_closed),
        .prot_on     (prot_on)
    );

    assign wr_permit = wr_valid && !cmd_step && (!prot_on || (win_open && room));

    // R5: an open window implies protection is on
    a_r5_win_needs_prot: assert property (@(posedge clk) disable iff (seq_rst)
        win_open |-> prot_on);

    // R6: protected with the window shut, nothing reaches the array
    a_r6_locked_refuses: assert property (@(posedge clk) disable iff (seq_rst)
        (prot_on && !win_open) |-> !wr_permit);

    // R11: a soft reset alone never moves the protection flag
    a_r11_rst_keeps_flag: assert property (@(posedge clk)
        ($past(rst) && !$past(factory_clr) && !$past(unlock_hit) && !$past(load_closed))
            |-> prot_on == $past(prot_on));

endmodule

// File: tb/wp_guard_test.sv
module wp_guard_test;

    logic        clk = 1'b0;
    logic        rst, factory_clr, wr_valid, load_closed;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_permit, prot_on, win_open;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wp_guard uut (
        .clk         (clk),
        .rst         (rst),
        .factory_clr (factory_clr),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .load_closed (load_closed),
        .wr_permit   (wr_permit),
        .prot_on     (prot_on),
        .win_open    (win_open)
    );

    // entry: {addr[39:24], data[23:16], req[15:8], 3'b0, valid, closed, permit, prot, win}
    localparam int NV = 27;
    localparam logic [39:0] VEC [NV] = '{
        {16'h0010, 8'h33, 8'd2,  8'h14},  // R2 free write
        {16'h5555, 8'hAA, 8'd9,  8'h10},  // R9 step refused
        {16'h2AAA, 8'h55, 8'd9,  8'h10},  // R9
        {16'h5555, 8'hA0, 8'd3,  8'h13},  // R3 unlock done
        {16'h0100, 8'h11, 8'd4,  8'h17},  // R4 window write
        {16'h0101, 8'h22, 8'd4,  8'h17},  // R4
        {16'h0000, 8'h00, 8'd5,  8'h0A},  // R5 close
        {16'h0102, 8'h44, 8'd6,  8'h12},  // R6 locked
        {16'h5555, 8'hAA, 8'd7,  8'h12},  // R7
        {16'h2AAA, 8'h55, 8'd7,  8'h12},  // R7
        {16'h0005, 8'h77, 8'd7,  8'h12},  // R7 stray write
        {16'h5555, 8'hA0, 8'd7,  8'h12},  // R7 no unlock
        {16'hD555, 8'hAA, 8'd10, 8'h12},  // R10 bit 15 set
        {16'hAAAA, 8'h55, 8'd10, 8'h12},  // R10
        {16'h5555, 8'hA0, 8'd10, 8'h13},  // R10 unlock
        {16'h0000, 8'h00, 8'd5,  8'h0A},  // R5 close
        {16'h5555, 8'hAA, 8'd8,  8'h12},  // R8 disable command
        {16'h2AAA, 8'h55, 8'd8,  8'h12},
        {16'h5555, 8'h80, 8'd8,  8'h12},
        {16'h5555, 8'hAA, 8'd8,  8'h12},
        {16'h2AAA, 8'h55, 8'd8,  8'h12},
        {16'h5555, 8'h20, 8'd8,  8'h12},
        {16'h0200, 8'h66, 8'd8,  8'h12},  // R8 still protected
        {16'h0000, 8'h00, 8'd8,  8'h08},  // R8 commit clears
        {16'h0200, 8'h66, 8'd8,  8'h14},  // R8 free again
        {16'h5555, 8'hAA, 8'd9,  8'h10},  // R9 step while open
        {16'h0003, 8'h88, 8'd7,  8'h14}   // R7 mismatch permitted
    };

    task automatic chk(input logic act, input logic exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] a, input logic [7:0] d,
                        input logic c, input logic ep, input logic eprot,
                        input logic ewin, input string req);
        @(negedge clk);
        wr_valid = v; wr_addr = a; wr_data = d; load_closed = c;
        #5;
        chk(wr_permit, ep, {req, " wr_permit"});
        @(posedge clk);
        #2;
        wr_valid = 1'b0; load_closed = 1'b0;
        chk(prot_on, eprot, {req, " prot_on"});
        chk(win_open, ewin, {req, " win_open"});
    endtask

    task automatic unlock();
        step(1, 16'h5555, 8'hAA, 0, 0, prot_on, 0, "R3 key1");
        step(1, 16'h2AAA, 8'h55, 0, 0, prot_on, 0, "R3 key2");
        step(1, 16'h5555, 8'hA0, 0, 0, 1, 1, "R3 key3");
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; factory_clr = 1; wr_valid = 0; load_closed = 0;
        wr_addr = '0; wr_data = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0; factory_clr = 0;
        #2;
        chk(prot_on, 1'b0, "R1 reset prot_on");
        chk(win_open, 1'b0, "R1 reset win_open");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][4], VEC[i][39:24], VEC[i][23:16], VEC[i][3], VEC[i][2],
                 VEC[i][1], VEC[i][0], $sformatf("R%0d vec%0d", VEC[i][15:8], i));
        end

        // R4: exactly PAGE_BYTES writes fit in one window
        unlock();
        for (int i = 0; i < 128; i++)
            step(1, 16'h0300 + 16'(i), 8'(i), 0, 1, 1, 1, "R4 page byte");
        step(1, 16'h0380, 8'hEE, 0, 0, 1, 1, "R4 over limit");
        step(0, 16'h0000, 8'h00, 1, 0, 1, 0, "R5 close after page");

        // R12: close pulse mid-sequence aborts it
        step(1, 16'h5555, 8'hAA, 0, 0, 1, 0, "R12 key1");
        step(1, 16'h2AAA, 8'h55, 0, 0, 1, 0, "R12 key2");
        step(0, 16'h0000, 8'h00, 1, 0, 1, 0, "R12 abort");
        step(1, 16'h5555, 8'hA0, 0, 0, 1, 0, "R12 late key3");

        // R11: soft reset keeps the flag, shuts the window
        unlock();
        @(negedge clk); rst = 1;
        @(posedge clk); #2; rst = 0;
        chk(prot_on, 1'b1, "R11 prot_on kept");
        chk(win_open, 1'b0, "R11 window shut");
        step(1, 16'h0400, 8'h5A, 0, 0, 1, 0, "R11 write refused");

        // R1: factory clear restores protection off
        @(negedge clk); factory_clr = 1;
        @(posedge clk); #2; factory_clr = 0;
        chk(prot_on, 1'b0, "R1 factory prot_on");
        chk(win_open, 1'b0, "R1 factory win_open");
        step(1, 16'h0401, 8'hA5, 0, 1, 0, 0, "R1 R2 free after clear");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule